// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry and Extend Flags

This unit moves the bits of a byte, word or long operand left or right by a count taken from the instruction. It offers four kinds of movement: a logical shift that brings in zeros, an arithmetic shift whose right form copies the sign bit into the vacated positions, a plain rotate that feeds each bit leaving one end back into the other end, and a rotate that runs through the extend bit, so the loop is one bit longer than the operand. The unit works out the result and the new carry, extend, zero and negative flags in one combinational pass and registers them, so they appear one clock after the request.

The unit sits beside the arithmetic datapath of a small processor. The control logic supplies the operand, the size, the kind of operation, the direction, the count and the present extend flag. It takes the registered result and flags back, either to a data register or to the condition-code register, which is held outside this block.

Top module: `shift_rotate_unit`

## Requirements
- R1: When `in_valid` is 1 at a rising edge, `out_valid` is 1 after that edge and `result` and the four flags show that request. When `in_valid` is 0, `out_valid` is 0 after the edge and the other outputs keep their values. A synchronous reset with `rst_n` at 0 clears all outputs to 0.
- R2: `size` 0 selects the low 8 bits, 1 the low 16 bits, and 2 or 3 all 32 bits. Only the selected bits are shifted. The bits of `result` above the selected size equal the same bits of `operand`.
- R3: With `op` 0, a logical shift, the vacated positions fill with 0. For a nonzero count, C and X both equal the last bit shifted out. A count larger than the size gives a zero result and C = X = 0.
- R4: With `op` 1, an arithmetic shift, a right shift fills with copies of the sign bit (the top bit of the selected size). A count of the size or more gives all sign bits and C = X = sign. A left shift behaves exactly like a logical left shift.
- R5: With `op` 2, a plain rotate, the bit leaving one end enters the other end, so the count acts modulo the size. For a nonzero count, C is the last bit moved: the result's low bit for a left rotate and its top selected bit for a right rotate. X always keeps `x_in`.
- R6: With `op` 3, a rotate through extend, the selected bits and X form one loop of size+1 bits, with X next to the top bit. The count acts modulo size+1. The new X is the bit that ends in the extend position, and C equals the new X.
- R7: With a count of 0, the result equals the operand and X keeps `x_in`. C is 0 for `op` 0, 1 and 2, and C equals `x_in` for `op` 3.
- R8: Z is 1 exactly when the selected bits of the result are all 0. N equals the top selected bit of the result.
- R9: `shift_left` at 1 moves bits toward the most significant end and at 0 toward the least significant end. `count` is an unsigned value from 0 to 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; loads the output registers |
| operand | input | 32 | Value to shift or rotate |
| size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| op | input | 2 | 0 logical, 1 arithmetic, 2 rotate, 3 rotate through extend |
| shift_left | input | 1 | 1 left, 0 right |
| count | input | 6 | Number of bit positions, 0 to 63 |
| x_in | input | 1 | Present extend flag |
| out_valid | output | 1 | Registered copy of in_valid |
| result | output | 32 | Shifted value, bits above size passed through |
| c_out | output | 1 | New carry flag |
| x_out | output | 1 | New extend flag |
| z_out | output | 1 | New zero flag |
| n_out | output | 1 | New negative flag |

## Verification
The bench targets the count boundaries for each size. These are a count of zero, exactly the size, one past the size, size+1 for the rotate through extend, and 63. A design that takes the flag bit from the wrong end would give the wrong C at a count equal to the size. A design that wraps shift counts instead of flushing would leave nonzero bits where zeros are due. A design that wraps the extend rotation modulo the size instead of size+1 would return a changed value and a wrong X when the count is size+1. Other cases check that a byte or word request leaves the upper operand bits untouched, that a plain rotate never changes X, and that a zero count clears C except in the extend rotate. Any of these faults shows up as a mismatch against the bench's own bit-by-bit model.

// File: rtl/sru_pkg.sv
// Package: shared encodings for the shift and rotate unit.
// Assumes: the op and size codes below are fixed by the instruction decoder.
package sru_pkg;

    typedef enum logic [1:0] {
        SR_LOGIC = 2'd0,
        SR_ARITH = 2'd1,
        SR_ROT   = 2'd2,
        SR_ROTX  = 2'd3
    } sr_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LONG3 = 2'd3
    } sr_size_e;

endpackage

// File: rtl/sr_lane.sv
// Module: one fixed-width shift/rotate lane.
// Does: computes the result, carry and extend for one operand width W.
// Assumes: CW wide count, 2**CW > W+1, op codes from sru_pkg.
module sr_lane
    import sru_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 6
) (
    input  logic [W-1:0]  val,
    input  logic [1:0]    op,
    input  logic          left,
    input  logic [CW-1:0] cnt,
    input  logic          xin,
    output logic [W-1:0]  res,
    output logic          cout,
    output logic          xout
);

    localparam int KW = $clog2(W);
    localparam int XW = W + 1;

    logic [W:0]    lsh_ext;   // {last out, result} for left shifts
    logic [W:0]    lrs_ext;   // {result, last out} for logical right
    logic [W:0]    ars_ext;   // {result, last out} for arithmetic right
    logic [KW-1:0] k_rot;
    logic [W-1:0]  rol_v;
    logic [W-1:0]  ror_v;
    logic [CW-1:0] k_rox;
    logic [XW-1:0] loop_v;
    logic [XW-1:0] roxl_v;
    logic [XW-1:0] roxr_v;

    // Shift paths: one spare bit catches the last bit that leaves the operand.
    assign lsh_ext = {1'b0, val} << cnt;
    assign lrs_ext = {val, 1'b0} >> cnt;
    assign ars_ext = $signed({val, 1'b0}) >>> cnt;

    // Plain rotate: the count is taken modulo the power-of-two width.
    assign k_rot = cnt[KW-1:0];
    assign rol_v = (val << k_rot) | (val >> (W - int'(k_rot)));
    assign ror_v = (val >> k_rot) | (val << (W - int'(k_rot)));

    // Rotate through extend: loop of W+1 bits, count modulo W+1.
    assign loop_v = {xin, val};
    assign k_rox  = cnt % CW'(XW);
    assign roxl_v = (loop_v << k_rox) | (loop_v >> (XW - int'(k_rox)));
    assign roxr_v = (loop_v >> k_rox) | (loop_v << (XW - int'(k_rox)));

    // Pick the path for the requested operation and derive C and X.
    always_comb begin
        res  = val;
        cout = 1'b0;
        xout = xin;
        case (op)
            SR_LOGIC, SR_ARITH: begin
                if (left)
                    {cout, res} = lsh_ext;
                else if (op == SR_ARITH)
                    {res, cout} = ars_ext;
                else
                    {res, cout} = lrs_ext;
                if (cnt != '0)
                    xout = cout;
            end
            SR_ROT: begin
                if (cnt != '0) begin
                    res  = left ? rol_v : ror_v;
                    cout = left ? rol_v[0] : ror_v[W-1];
                end
            end
            default: begin
                {xout, res} = left ? roxl_v : roxr_v;
                cout        = xout;
            end
        endcase
    end

endmodule

// File: rtl/sr_merge.sv
// Module: size selection and zero/negative flags.
// Does: picks the lane for the requested size, passes through the upper
//       operand bits and forms Z and N from the sized result.
// Assumes: lane g holds a width 8<<g result, zero-extended to DW bits.
module sr_merge #(
    parameter int DW = 32,
    parameter int NL = 3
) (
    input  logic [DW-1:0]         operand,
    input  logic [1:0]            size,
    input  logic [NL-1:0][DW-1:0] lane_res,
    input  logic [NL-1:0]         lane_c,
    input  logic [NL-1:0]         lane_x,
    output logic [DW-1:0]         result,
    output logic                  c,
    output logic                  x,
    output logic                  z,
    output logic                  n
);

    int            idx;
    int            wsel;
    logic [DW-1:0] mask;
    logic [DW-1:0] topbit;
    logic [DW-1:0] sized;

    // Choose the lane; size codes above the widest lane map to it.
    always_comb begin
        idx    = (int'(size) > NL - 1) ? NL - 1 : int'(size);
        wsel   = 8 << idx;
        mask   = {DW{1'b1}} >> (DW - wsel);
        topbit = DW'(1) << (wsel - 1);
        sized  = lane_res[idx] & mask;
        result = (operand & ~mask) | sized;
        c      = lane_c[idx];
        x      = lane_x[idx];
        z      = (sized == '0);
        n      = |(sized & topbit);
    end

endmodule

// File: rtl/shift_rotate_unit.sv
// Module: top of the shift and rotate unit.
// Does: runs one lane per operand size in parallel, selects by size and
//       registers result and flags one clock after in_valid.
// Assumes: synchronous active-low reset; DATA_W = 8 << (number of lanes - 1).
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [1:0]        size,
    input  logic [1:0]        op,
    input  logic              shift_left,
    input  logic [CNT_W-1:0]  count,
    input  logic              x_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              c_out,
    output logic              x_out,
    output logic              z_out,
    output logic              n_out
);

    localparam int NL = $clog2(DATA_W / 8) + 1;

    logic [NL-1:0][DATA_W-1:0] lane_res;
    logic [NL-1:0]             lane_c;
    logic [NL-1:0]             lane_x;
    logic [DATA_W-1:0]         nxt_res;
    logic                      nxt_c;
    logic                      nxt_x;
    logic                      nxt_z;
    logic                      nxt_n;

    // One lane per supported operand width.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] lres;
        sr_lane #(.W(LW), .CW(CNT_W)) u_lane (
            .val  (operand[LW-1:0]),
            .op   (op),
            .left (shift_left),
            .cnt  (count),
            .xin  (x_in),
            .res  (lres),
            .cout (lane_c[g]),
            .xout (lane_x[g])
        );
        assign lane_res[g] = DATA_W'(lres);
    end

    sr_merge #(.DW(DATA_W), .NL(NL)) u_merge (
        .operand  (operand),
        .size     (size),
        .lane_res (lane_res),
        .lane_c   (lane_c),
        .lane_x   (lane_x),
        .result   (nxt_res),
        .c        (nxt_c),
        .x        (nxt_x),
        .z        (nxt_z),
        .n        (nxt_n)
    );

    // Output registers: load on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            c_out     <= 1'b0;
            x_out     <= 1'b0;
            z_out     <= 1'b0;
            n_out     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt_res;
                c_out  <= nxt_c;
                x_out  <= nxt_x;
                z_out  <= nxt_z;
                n_out  <= nxt_n;
            end
        end
    end

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(c_out) && $stable(x_out)));

    a_r5_rot_keeps_x: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == SR_ROT) |=> (x_out == $past(x_in)));

    a_r6_rox_c_is_x: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == SR_ROTX) |=> (c_out == x_out));

    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && count == '0 && op != SR_ROTX)
        |=> (!c_out && x_out == $past(x_in) && result == $past(operand)));

    a_r3_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == SR_LOGIC && count > CNT_W'(DATA_W))
        |=> (z_out && !c_out && !x_out));

    a_r8_zn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(z_out && n_out));

endmodule

// File: tb/sim_shift_rotate_unit.sv
module sim_shift_rotate_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] operand;
    logic [1:0]  size;
    logic [1:0]  op;
    logic        shift_left;
    logic [5:0]  count;
    logic        x_in;
    logic        out_valid;
    logic [31:0] result;
    logic        c_out, x_out, z_out, n_out;

    int total = 0;
    int fails = 0;

    // expected state after the next rising edge
    logic        e_valid;
    logic [31:0] e_res, e_mask;
    logic        e_c, e_x, e_z, e_n;
    string       e_tag;

    always #4 clk = ~clk;

    shift_rotate_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .size(size), .op(op), .shift_left(shift_left), .count(count),
        .x_in(x_in), .out_valid(out_valid), .result(result),
        .c_out(c_out), .x_out(x_out), .z_out(z_out), .n_out(n_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bit-by-bit reference: one position per step, as the requirements read.
    task automatic model(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] o,
                         input logic l, input logic [5:0] cnt, input logic xi,
                         output logic [31:0] r, output logic [31:0] m,
                         output logic c, output logic x, output logic z, output logic n);
        int w;
        logic [63:0] v, mk;
        logic ob, fill;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mk = (64'd1 << w) - 64'd1;
        v  = {32'd0, a} & mk;
        c  = 1'b0;
        x  = xi;
        if (cnt == 6'd0) begin
            if (o == 2'd3) c = xi;
        end else begin
            for (int i = 0; i < int'(cnt); i++) begin
                if (l) begin
                    ob   = v[w-1];
                    fill = (o == 2'd2) ? ob : (o == 2'd3) ? x : 1'b0;
                    v    = {v[62:0], fill} & mk;
                end else begin
                    ob   = v[0];
                    fill = (o == 2'd1) ? v[w-1] : (o == 2'd2) ? ob : (o == 2'd3) ? x : 1'b0;
                    v    = (v >> 1) | ({63'd0, fill} << (w - 1));
                end
                c = ob;
                if (o != 2'd2) x = ob;
            end
        end
        r = (a & ~mk[31:0]) | v[31:0];
        m = mk[31:0];
        z = (v == 64'd0);
        n = v[w-1];
    endtask

    function automatic string tag_of(input logic [1:0] o, input logic [5:0] cnt);
        if (cnt == 6'd0) return "R7";
        case (o)
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic compare();
        chk("R1 valid", {31'd0, out_valid}, {31'd0, e_valid});
        chk({e_tag, " R9 result"}, result & e_mask, e_res & e_mask);
        chk("R2 upper bits", result & ~e_mask, e_res & ~e_mask);
        chk({e_tag, " carry"}, {31'd0, c_out}, {31'd0, e_c});
        chk({e_tag, " extend"}, {31'd0, x_out}, {31'd0, e_x});
        chk("R8 zero", {31'd0, z_out}, {31'd0, e_z});
        chk("R8 negative", {31'd0, n_out}, {31'd0, e_n});
    endtask

    task automatic apply(input logic v, input logic [31:0] a, input logic [1:0] sz,
                         input logic [1:0] o, input logic l, input logic [5:0] cnt,
                         input logic xi);
        @(negedge clk);
        compare();
        in_valid   = v;
        operand    = a;
        size       = sz;
        op         = o;
        shift_left = l;
        count      = cnt;
        x_in       = xi;
        e_valid    = v;
        if (v) begin
            model(a, sz, o, l, cnt, xi, e_res, e_mask, e_c, e_x, e_z, e_n);
            e_tag = tag_of(o, cnt);
        end else begin
            e_tag = "R1 hold";
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset result", result, 32'd0);
        chk("R1 reset flags", {28'd0, c_out, x_out, z_out, n_out}, 32'd0);
        rst_n   = 1'b1;
        e_valid = 1'b0;
        e_res   = '0;
        e_mask  = 32'hFFFF_FFFF;
        e_c = 1'b0; e_x = 1'b0; e_z = 1'b0; e_n = 1'b0;
        e_tag   = "R1 idle";
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; in_valid = 1'b0; operand = '0; size = '0; op = '0;
        shift_left = 1'b0; count = '0; x_in = 1'b0;
        do_reset();

        // R3 logical shifts at the count boundaries
        apply(1, 32'h0000_0080, 2'd0, 2'd0, 1, 6'd1, 0);
        apply(1, 32'h0000_0001, 2'd0, 2'd0, 1, 6'd8, 0);
        apply(1, 32'h0000_00FF, 2'd0, 2'd0, 1, 6'd9, 1);
        apply(1, 32'h8000_0001, 2'd2, 2'd0, 0, 6'd1, 0);
        apply(1, 32'hFFFF_FFFF, 2'd2, 2'd0, 0, 6'd63, 1);
        apply(1, 32'h1234_8000, 2'd1, 2'd0, 0, 6'd16, 0);
        // R4 arithmetic shifts
        apply(1, 32'h0000_0080, 2'd0, 2'd1, 0, 6'd3, 0);
        apply(1, 32'h8000_0000, 2'd2, 2'd1, 0, 6'd40, 0);
        apply(1, 32'h4000_0000, 2'd3, 2'd1, 1, 6'd2, 0);
        apply(1, 32'hAAAA_7FFF, 2'd1, 2'd1, 0, 6'd15, 1);
        // R5 plain rotates; X must stay
        apply(1, 32'h0000_0081, 2'd0, 2'd2, 1, 6'd1, 0);
        apply(1, 32'h0000_8001, 2'd1, 2'd2, 0, 6'd16, 1);
        apply(1, 32'hF000_000F, 2'd2, 2'd2, 0, 6'd36, 0);
        // R6 rotate through extend, incl. size+1
        apply(1, 32'h0000_0080, 2'd0, 2'd3, 1, 6'd1, 0);
        apply(1, 32'h0000_005A, 2'd0, 2'd3, 1, 6'd9, 1);
        apply(1, 32'h0000_0001, 2'd1, 2'd3, 0, 6'd17, 0);
        apply(1, 32'h8000_0001, 2'd2, 2'd3, 0, 6'd33, 1);
        apply(1, 32'h0000_0001, 2'd2, 2'd3, 0, 6'd1, 1);
        // R7 zero count
        apply(1, 32'hDEAD_BEEF, 2'd2, 2'd0, 1, 6'd0, 1);
        apply(1, 32'h0000_00F0, 2'd0, 2'd2, 0, 6'd0, 1);
        apply(1, 32'h0000_00F0, 2'd0, 2'd3, 1, 6'd0, 1);
        // R2 pass-through above the selected size
        apply(1, 32'hAABB_CC80, 2'd0, 2'd0, 1, 6'd1, 0);
        apply(1, 32'hAABB_8000, 2'd1, 2'd2, 1, 6'd4, 0);
        // R1 hold: inputs change without a request
        apply(0, 32'h1111_1111, 2'd2, 2'd1, 0, 6'd5, 1);
        apply(0, 32'h0, 2'd0, 2'd3, 1, 6'd7, 0);

        for (int i = 0; i < 600; i++) begin
            apply(($urandom % 5) != 0, $urandom, 2'($urandom), 2'($urandom),
                  1'($urandom), 6'($urandom), 1'($urandom));
        end

        // R1 reset in the middle of traffic
        apply(1, 32'hFFFF_FFFF, 2'd2, 2'd1, 0, 6'd3, 1);
        do_reset();
        apply(1, 32'h0000_0003, 2'd0, 2'd3, 0, 6'd2, 0);
        apply(0, 32'h0, 2'd0, 2'd0, 0, 6'd0, 0);
        @(negedge clk);
        compare();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule